// File: doc/BRIEF.md
# DMA Channel Request Gating Unit

This unit sits inside one channel of a DMA engine. It decides when the channel may take a source-side or a destination-side transaction request and hand it to the bus master. The decision depends on four things: how full the channel FIFO is, which threshold mode is programmed, whether the destination controls the flow, and how many transfers are left in the block. It also picks the request line of the selected hardware handshake interface, or a software request bit instead. When a serviced burst completes, it returns the acknowledge to the same interface that made the request. It also forms the four bus protection attribute bits.

Only one burst is in flight at a time. An accepted request makes a one-cycle grant pulse. The unit then stays busy until the bus master reports that the burst is done. It then spends one cycle acknowledging and returns to idle. Requests that arrive while the unit is busy or acknowledging are masked.

Top module: `dma_req_gate`

## Requirements
- R1: With the half-threshold mode off (`cfg_half_mode`=0), a destination request is eligible when `fifo_level` >= 1. A source request is eligible when `fifo_level` < FIFO_DEPTH.
- R2: With `cfg_half_mode`=1 and a burst that is not final, a destination request is eligible only when `fifo_level` >= FIFO_DEPTH/2. A source request is eligible only when `fifo_level` < FIFO_DEPTH/2.
- R3: A burst is final for a side when that side's remaining count is at or below `burst_len`. A final burst uses the R1 rule even in half-threshold mode. A side whose remaining count is 0 is never granted.
- R4: When `cfg_fc_hold`=1 and `cfg_dst_fc`=1, a source request is granted only after a destination request has been seen since the last source grant. When either bit is 0, no such hold applies.
- R5: `hprot` equals {`cfg_prot`[2:0], 1'b1}, so bit 0 always marks a data access.
- R6: When a side's software-select bit is 0, its request is `hs_req`[index] and all other `hs_req` lines are ignored. When the bit is 1, its request is `sw_src_req` or `sw_dst_req` and `hs_req` is ignored.
- R7: An accepted request raises `src_gnt` or `dst_gnt` for exactly one cycle, in the cycle after acceptance. At the same time `busy` goes to 1. `busy` stays 1 until the cycle after `xfer_done` is seen, plus one acknowledge cycle. No grant is made while `busy` is 1.
- R8: `hs_ack` is non-zero only in the acknowledge cycle. In that cycle it is one-hot at bit `cfg_src_idx` or `cfg_dst_idx` of the serviced side when that side uses hardware handshaking, and all zero when it uses software handshaking.
- R9: When both sides are eligible in the same idle cycle, the destination is granted and the source is not.
- R10: After a synchronous reset (`rst_n`=0), `src_gnt`, `dst_gnt`, `busy` and `hs_ack` are 0, and no destination request has been recorded for R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fc_hold | input | 1 | Flow-control hold mode: 1 stops source prefetch |
| cfg_dst_fc | input | 1 | Destination peripheral is the flow controller |
| cfg_half_mode | input | 1 | 1 selects the half-FIFO threshold |
| cfg_prot | input | 3 | Protection attribute bits for hprot[3:1] |
| cfg_src_sw | input | 1 | Source uses software handshaking |
| cfg_dst_sw | input | 1 | Destination uses software handshaking |
| cfg_src_idx | input | IDX_W | Handshake interface index of the source |
| cfg_dst_idx | input | IDX_W | Handshake interface index of the destination |
| hs_req | input | NUM_HS | Hardware request lines from the peripherals |
| sw_src_req | input | 1 | Software source request |
| sw_dst_req | input | 1 | Software destination request |
| fifo_level | input | LVL_W | FIFO fill level in transfer units |
| src_left | input | CNT_W | Source transfers left in the block |
| dst_left | input | CNT_W | Destination transfers left in the block |
| burst_len | input | CNT_W | Programmed burst length in transfers |
| xfer_done | input | 1 | Bus master reports that the granted burst is complete |
| src_gnt | output | 1 | One-cycle source grant |
| dst_gnt | output | 1 | One-cycle destination grant |
| busy | output | 1 | A burst is in flight or being acknowledged |
| hs_ack | output | NUM_HS | Acknowledge lines to the peripherals |
| hprot | output | 4 | Bus protection attribute bits |

## Verification
The assertions check several things on every cycle. Grants last one cycle, and no grant follows a busy cycle. The acknowledge vector is at most one-hot and is silent outside the acknowledge cycle. An exhausted side never reads as eligible, and a source grant never slips through an active hold. The bench's scenarios cover the rest: the exact threshold levels on each side in both modes, the final-burst waiver, the hold being armed and cleared by destination requests, destination-over-source priority, routing of requests and acknowledges for every interface index, and the software-handshake path.

// File: rtl/dma_gate_pkg.sv
// Package: shared types for the DMA channel request gating unit.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package dma_gate_pkg;

    // Channel sequencing state: waiting, burst in flight, acknowledge cycle.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_ACK  = 2'd2
    } gate_state_e;

    // Which side of the channel the in-flight burst serves.
    typedef enum logic {
        SIDE_SRC = 1'b0,
        SIDE_DST = 1'b1
    } gate_side_e;

    // Forms the bus protection attributes; bit 0 marks a data access.
    function automatic logic [3:0] build_hprot(input logic [2:0] prot);
        return {prot, 1'b1};
    endfunction

endpackage

// File: rtl/dma_hs_route.sv
// Module: dma_hs_route
// Selects the request line of each channel side, either the hardware line
// named by the side's interface index or a software request bit. It also
// steers the acknowledge to the interface of the side that was serviced.
// Assumes: indices at or above NUM_HS select no line (request reads 0).
module dma_hs_route
    import dma_gate_pkg::*;
#(
    parameter int NUM_HS = 4,
    parameter int IDX_W  = (NUM_HS > 1) ? $clog2(NUM_HS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HS-1:0] hs_req,
    input  logic              sw_src_req,
    input  logic              sw_dst_req,
    input  logic              src_sw,
    input  logic              dst_sw,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              ack_en,
    input  gate_side_e        ack_side,
    output logic              src_req,
    output logic              dst_req,
    output logic [NUM_HS-1:0] hs_ack
);

    logic src_hw;
    logic dst_hw;

    // Pick the hardware request line addressed by each side's index.
    always_comb begin
        src_hw = 1'b0;
        dst_hw = 1'b0;
        for (int i = 0; i < NUM_HS; i++) begin
            if (src_idx == IDX_W'(i)) src_hw = hs_req[i];
            if (dst_idx == IDX_W'(i)) dst_hw = hs_req[i];
        end
    end

    // Choose software or hardware request per side.
    always_comb begin
        src_req = src_sw ? sw_src_req : src_hw;
        dst_req = dst_sw ? sw_dst_req : dst_hw;
    end

    // One acknowledge decoder per interface.
    for (genvar g = 0; g < NUM_HS; g++) begin : g_ack
        logic hit_src;
        logic hit_dst;
        assign hit_src = !src_sw && (src_idx == IDX_W'(g));
        assign hit_dst = !dst_sw && (dst_idx == IDX_W'(g));
        assign hs_ack[g] = ack_en &&
                           ((ack_side == SIDE_DST) ? hit_dst : hit_src);
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_ack)); // R8

    AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_en |-> (hs_ack == '0)); // R8

endmodule

// File: rtl/dma_fifo_thresh.sv
// Module: dma_fifo_thresh
// Decides whether one side of the channel may start a burst, given the FIFO
// fill level, the threshold mode and the transfers left in the block.
// A destination side needs data in the FIFO; a source side needs space.
// Assumes: fifo_level never exceeds DEPTH.
module dma_fifo_thresh #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 8,
    parameter bit IS_DST = 1'b0,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             half_mode,
    input  logic [CNT_W-1:0] left,
    input  logic [CNT_W-1:0] burst_len,
    output logic             ok
);

    localparam int HALF = DEPTH / 2;

    logic has_work;
    logic final_burst;
    logic base_ok;
    logic half_ok;

    // Classify the burst: any work left, and whether it ends the block.
    always_comb begin
        has_work    = (left != '0);
        final_burst = (left <= burst_len);
    end

    // Single-transfer and half-depth conditions for this side.
    if (IS_DST) begin : g_dst
        always_comb begin
            base_ok = (fifo_level >= LVL_W'(1));
            half_ok = (fifo_level >= LVL_W'(HALF));
        end
    end else begin : g_src
        always_comb begin
            base_ok = (fifo_level < LVL_W'(DEPTH));
            half_ok = (fifo_level < LVL_W'(HALF));
        end
    end

    // Pick the rule that applies; a final burst waives the half-depth rule.
    always_comb begin
        ok = has_work && ((half_mode && !final_burst) ? half_ok : base_ok);
    end

    AST_EMPTY_BLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (left == '0) |-> !ok); // R3

    AST_FULL_SRC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_DST && fifo_level == LVL_W'(DEPTH)) |-> !ok); // R1

endmodule

// File: rtl/dma_flow_hold.sv
// Module: dma_flow_hold
// Tracks whether a destination request has been seen since the last source
// grant. When the hold is active, a source burst is allowed only after such
// a request, so the source never prefetches ahead of the destination.
// Assumes: src_take is high only in the cycle a source burst is accepted.
module dma_flow_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic dst_req,
    input  logic src_take,
    output logic src_allow
);

    logic seen_q;

    // Record a destination request; a source grant consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= dst_req | (seen_q & ~src_take);
        end
    end

    // Let the source through when the hold is off or a request was seen.
    always_comb begin
        src_allow = !hold_en || seen_q;
    end

    AST_TAKE_ONLY_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && src_take) |-> seen_q); // R4

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_take && !dst_req) |=> !seen_q); // R4

endmodule

// File: rtl/dma_req_gate.sv
// Module: dma_req_gate (top)
// Channel request gating: routes handshake requests, applies the FIFO
// threshold and flow-control hold, grants one burst at a time with the
// destination side first, waits for the burst to finish, then returns one
// acknowledge cycle. Also forms the bus protection attributes.
// Assumes: xfer_done is raised by the bus master only for a granted burst.
module dma_req_gate
    import dma_gate_pkg::*;
#(
    parameter int NUM_HS     = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 8,
    localparam int IDX_W     = (NUM_HS > 1) ? $clog2(NUM_HS) : 1,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fc_hold,
    input  logic              cfg_dst_fc,
    input  logic              cfg_half_mode,
    input  logic [2:0]        cfg_prot,
    input  logic              cfg_src_sw,
    input  logic              cfg_dst_sw,
    input  logic [IDX_W-1:0]  cfg_src_idx,
    input  logic [IDX_W-1:0]  cfg_dst_idx,
    input  logic [NUM_HS-1:0] hs_req,
    input  logic              sw_src_req,
    input  logic              sw_dst_req,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [CNT_W-1:0]  src_left,
    input  logic [CNT_W-1:0]  dst_left,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic              xfer_done,
    output logic              src_gnt,
    output logic              dst_gnt,
    output logic              busy,
    output logic [NUM_HS-1:0] hs_ack,
    output logic [3:0]        hprot
);

    gate_state_e state_q;
    gate_side_e  side_q;
    logic        gnt_q;

    logic        src_req;
    logic        dst_req;
    logic [1:0]  side_ok;
    logic        src_allow;
    logic        dst_go;
    logic        src_go;
    logic        hold_en;

    // Request selection and acknowledge steering.
    dma_hs_route #(
        .NUM_HS (NUM_HS),
        .IDX_W  (IDX_W)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_req     (hs_req),
        .sw_src_req (sw_src_req),
        .sw_dst_req (sw_dst_req),
        .src_sw     (cfg_src_sw),
        .dst_sw     (cfg_dst_sw),
        .src_idx    (cfg_src_idx),
        .dst_idx    (cfg_dst_idx),
        .ack_en     (state_q == ST_ACK),
        .ack_side   (side_q),
        .src_req    (src_req),
        .dst_req    (dst_req),
        .hs_ack     (hs_ack)
    );

    // One threshold checker per side: index 0 source, index 1 destination.
    for (genvar s = 0; s < 2; s++) begin : g_side
        dma_fifo_thresh #(
            .DEPTH  (FIFO_DEPTH),
            .CNT_W  (CNT_W),
            .IS_DST (s == 1),
            .LVL_W  (LVL_W)
        ) u_thresh (
            .clk        (clk),
            .rst_n      (rst_n),
            .fifo_level (fifo_level),
            .half_mode  (cfg_half_mode),
            .left       ((s == 1) ? dst_left : src_left),
            .burst_len  (burst_len),
            .ok         (side_ok[s])
        );
    end

    // Hold is active only when the destination controls the flow.
    assign hold_en = cfg_fc_hold && cfg_dst_fc;

    dma_flow_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_en   (hold_en),
        .dst_req   (dst_req),
        .src_take  (src_go),
        .src_allow (src_allow)
    );

    // Acceptance in the idle state; destination wins a tie.
    always_comb begin
        dst_go = (state_q == ST_IDLE) && dst_req && side_ok[1];
        src_go = (state_q == ST_IDLE) && !dst_go && src_req &&
                 side_ok[0] && src_allow;
    end

    // Burst sequencer: idle, in flight, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            side_q  <= SIDE_SRC;
            gnt_q   <= 1'b0;
        end else begin
            gnt_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (dst_go) begin
                        state_q <= ST_BUSY;
                        side_q  <= SIDE_DST;
                        gnt_q   <= 1'b1;
                    end else if (src_go) begin
                        state_q <= ST_BUSY;
                        side_q  <= SIDE_SRC;
                        gnt_q   <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (xfer_done) state_q <= ST_ACK;
                end
                ST_ACK: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Grant pulses, busy flag and protection attributes.
    always_comb begin
        src_gnt = gnt_q && (side_q == SIDE_SRC);
        dst_gnt = gnt_q && (side_q == SIDE_DST);
        busy    = (state_q != ST_IDLE);
        hprot   = build_hprot(cfg_prot);
    end

    AST_GNT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_gnt || dst_gnt) |=> !(src_gnt || dst_gnt)); // R7

    AST_NO_GNT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(src_gnt || dst_gnt)); // R7

    AST_GNT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (src_gnt || dst_gnt) |-> busy); // R7

    AST_ACK_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACK) |-> (hs_ack == '0)); // R8

    AST_DST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_go && src_req && side_ok[0]) |=> (dst_gnt && !src_gnt)); // R9

    AST_HPROT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        hprot[0]); // R5

endmodule

// File: tb/dma_req_gate_tb.sv
// Bench for dma_req_gate: sweeps FIFO level, threshold mode and remaining
// counts on both sides, then exercises hold, priority, routing and the
// software-handshake path with arithmetically derived expectations.
module dma_req_gate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NHS   = 4;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;
    localparam int BL    = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_fc_hold, cfg_dst_fc, cfg_half_mode;
    logic [2:0] cfg_prot;
    logic       cfg_src_sw, cfg_dst_sw;
    logic [1:0] cfg_src_idx, cfg_dst_idx;
    logic [3:0] hs_req;
    logic       sw_src_req, sw_dst_req;
    logic [4:0] fifo_level;
    logic [7:0] src_left, dst_left, burst_len;
    logic       xfer_done;
    logic       src_gnt, dst_gnt, busy;
    logic [3:0] hs_ack;
    logic [3:0] hprot;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_req_gate #(.NUM_HS(NHS), .FIFO_DEPTH(DEPTH), .CNT_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_fc_hold(cfg_fc_hold), .cfg_dst_fc(cfg_dst_fc),
        .cfg_half_mode(cfg_half_mode), .cfg_prot(cfg_prot),
        .cfg_src_sw(cfg_src_sw), .cfg_dst_sw(cfg_dst_sw),
        .cfg_src_idx(cfg_src_idx), .cfg_dst_idx(cfg_dst_idx),
        .hs_req(hs_req), .sw_src_req(sw_src_req), .sw_dst_req(sw_dst_req),
        .fifo_level(fifo_level), .src_left(src_left), .dst_left(dst_left),
        .burst_len(burst_len), .xfer_done(xfer_done),
        .src_gnt(src_gnt), .dst_gnt(dst_gnt), .busy(busy),
        .hs_ack(hs_ack), .hprot(hprot)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Completes a granted burst; the acknowledge appears one cycle after done.
    task automatic complete(input string tag, input int exp_ack);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk({tag, " R8 ack"}, int'(hs_ack), exp_ack);
        @(negedge clk);
        chk({tag, " R7 idle after ack"}, int'(busy), 0);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One threshold sweep point on a single side.
    task automatic sweep_case(input bit is_dst, input int lvl, input bit half,
                              input int left);
        int  exp_g;
        bit  fin;
        string tag;
        fifo_level    = 5'(lvl);
        cfg_half_mode = half;
        burst_len     = 8'(BL);
        if (is_dst) begin
            dst_left = 8'(left); src_left = 8'd0; hs_req = 4'b0100;
        end else begin
            src_left = 8'(left); dst_left = 8'd0; hs_req = 4'b0010;
        end
        fin = (left <= BL);
        if (left == 0) exp_g = 0;
        else if (half && !fin) exp_g = is_dst ? int'(lvl >= HALF) : int'(lvl < HALF);
        else exp_g = is_dst ? int'(lvl >= 1) : int'(lvl < DEPTH);
        if (left == 0 || (half && fin)) tag = "R3";
        else if (half) tag = "R2";
        else tag = "R1";
        tag = $sformatf("%s dst=%0d lvl=%0d half=%0d left=%0d", tag, is_dst, lvl, half, left);
        @(negedge clk);
        chk(tag, int'(is_dst ? dst_gnt : src_gnt), exp_g);
        hs_req = 4'b0000;
        if (busy) complete(tag, is_dst ? 4 : 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int lefts [4] = '{0, 3, 4, 20};
        rst_n = 1'b0;
        cfg_fc_hold = 0; cfg_dst_fc = 0; cfg_half_mode = 0; cfg_prot = 3'd0;
        cfg_src_sw = 0; cfg_dst_sw = 0; cfg_src_idx = 2'd1; cfg_dst_idx = 2'd2;
        hs_req = 0; sw_src_req = 0; sw_dst_req = 0; fifo_level = 0;
        src_left = 0; dst_left = 0; burst_len = 8'(BL); xfer_done = 0;
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 grants", int'({src_gnt, dst_gnt}), 0);
        chk("R10 ack", int'(hs_ack), 0);
        rst_n = 1'b1;

        // R1 R2 R3 threshold sweep on both sides
        for (int d = 0; d < 2; d++)
            for (int h = 0; h < 2; h++)
                for (int li = 0; li < 4; li++)
                    for (int lv = 0; lv <= DEPTH; lv++)
                        sweep_case(d[0], lv, h[0], lefts[li]);

        // R9 priority: both eligible at level HALF
        fifo_level = 5'(HALF); cfg_half_mode = 0;
        src_left = 8'd20; dst_left = 8'd20; hs_req = 4'b0110;
        @(negedge clk);
        chk("R9 dst wins", int'(dst_gnt), 1);
        chk("R9 src loses", int'(src_gnt), 0);
        // R7 requests masked while busy
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 no grant while busy", int'({src_gnt, dst_gnt}), 0);
            chk("R7 busy held", int'(busy), 1);
        end
        hs_req = 4'b0000;
        complete("R9 dst", 4);

        // R4 flow hold, starting with no recorded destination request
        reset_dut();
        cfg_fc_hold = 1; cfg_dst_fc = 1; fifo_level = 0;
        src_left = 8'd20; dst_left = 8'd20; hs_req = 4'b0010;
        @(negedge clk);
        chk("R4 src held", int'(src_gnt), 0);
        @(negedge clk);
        chk("R4 src still held", int'(busy), 0);
        hs_req = 4'b0100;
        @(negedge clk);
        chk("R4 dst not eligible at empty", int'(dst_gnt), 0);
        hs_req = 4'b0010;
        @(negedge clk);
        chk("R4 src after dst request", int'(src_gnt), 1);
        hs_req = 4'b0000;
        complete("R4 src", 2);
        hs_req = 4'b0010;
        @(negedge clk);
        chk("R4 hold re-armed", int'(src_gnt), 0);
        cfg_dst_fc = 0;
        @(negedge clk);
        chk("R4 no hold without dst flow control", int'(src_gnt), 1);
        hs_req = 4'b0000;
        complete("R4 nohold", 2);
        cfg_fc_hold = 0;

        // R6 software source request; hardware line ignored
        cfg_src_sw = 1; dst_left = 8'd0; hs_req = 4'b0010; sw_src_req = 0;
        @(negedge clk);
        chk("R6 hw line ignored in sw mode", int'(src_gnt), 0);
        hs_req = 4'b0000; sw_src_req = 1;
        @(negedge clk);
        chk("R6 sw request granted", int'(src_gnt), 1);
        sw_src_req = 0;
        complete("R8 sw no ack", 0);
        cfg_src_sw = 0;

        // R6 R8 routing sweep over every destination interface index
        src_left = 8'd0; dst_left = 8'd20; fifo_level = 5'(HALF);
        for (int i = 0; i < NHS; i++) begin
            cfg_dst_idx = 2'(i);
            hs_req = ~(4'b0001 << i);
            @(negedge clk);
            chk($sformatf("R6 other lines ignored idx=%0d", i), int'(dst_gnt), 0);
            hs_req = 4'b0001 << i;
            @(negedge clk);
            chk($sformatf("R6 selected line idx=%0d", i), int'(dst_gnt), 1);
            hs_req = 4'b0000;
            complete($sformatf("R8 idx=%0d", i), 1 << i);
        end

        // R5 protection attributes
        for (int p = 0; p < 8; p++) begin
            cfg_prot = 3'(p);
            #1;
            chk($sformatf("R5 hprot prot=%0d", p), int'(hprot), p * 2 + 1);
        end

        finish_run();
    end

endmodule